// File: doc/BRIEF.md
# Rotate and Shift Instruction Byte Decoder

This block watches a stream of instruction bytes, one byte per accepted beat, and recognises the rotate/shift instruction group. The group comes in two byte layouts. The short layout is the prefix byte 0xCB followed by an opcode. The indexed layout is an index prefix (0xDD selects the first index register, 0xFD the second), then 0xCB, then a signed displacement byte, then the opcode. In the indexed layout the displacement arrives before the opcode, so the decoder keeps it in a register until the opcode byte lands.

On the beat that carries the last byte of an instruction, the decoder reports the operation, the operand, the index selection, the sign-extended displacement, the instruction length in bytes and the nominal cycle count. Malformed or unknown sequences raise a one-beat unsupported flag and return the decoder to its idle state. The decoder never executes the operation.

The input side is a valid/ready stream. `in_ready` is held high at all times because the decoder takes one byte every cycle and never applies back-pressure. A byte is consumed only on a cycle where `in_valid` is high. Cycles with `in_valid` low change nothing. The decoded outputs are plain pins: results are offered for one cycle and are not held for a consumer.

Top module: `bitop_decoder`

## Requirements
- R1: A synchronous reset returns the decoder to idle, so a partly received sequence is dropped. After reset, `dec_valid` and `dec_unsup` are 0.
- R2: `in_ready` is always 1. Beats with `in_valid` low leave the decode progress and the buffered displacement unchanged.
- R3: For 0xCB followed by an opcode with bits 7:6 = 00, `dec_valid` is 1 on the opcode beat. On that beat `dec_op` = opcode bits 5:3 (000 rotate-left circular, 001 rotate-right circular, 010 rotate-left through carry, 011 rotate-right through carry, 100 arithmetic shift left, 101 arithmetic shift right, 111 logical shift right), `dec_reg` = opcode bits 2:0, `dec_index` = 00, `dec_disp` = 0 and `dec_len` = 2.
- R4: Operand codes are B=000, C=001, D=010, E=011, H=100, L=101 and A=111, and 110 means memory. `dec_mem` is 1 exactly for code 110. In the short layout, `dec_cycles` is 8 for a register operand and 15 for the memory operand.
- R5: For the indexed layout (0xDD or 0xFD, then 0xCB, then d, then an opcode with bits 2:0 = 110), `dec_valid` is 1 on the opcode beat. On that beat `dec_index` is 01 for 0xDD and 10 for 0xFD, `dec_disp` is d sign-extended to 16 bits, `dec_mem` = 1, `dec_len` = 4 and `dec_cycles` = 23.
- R6: A byte other than 0xCB right after 0xDD or 0xFD pulses `dec_unsup` on that beat and returns the decoder to idle.
- R7: An indexed opcode whose bits 2:0 are not 110 pulses `dec_unsup` on the opcode beat instead of `dec_valid`.
- R8: In either layout, an opcode whose bits 7:6 are not 00, or whose bits 5:3 are 110, pulses `dec_unsup` instead of `dec_valid`.
- R9: `dec_valid` and `dec_unsup` each last one cycle, are never high together, and occur only on a beat with `in_valid` high.
- R10: While idle, bytes other than 0xCB, 0xDD and 0xFD are ignored and produce no pulse. This includes a bare opcode byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte present on `in_byte` |
| in_ready | output | 1 | Always 1; the decoder never stalls |
| in_byte | input | 8 | Instruction byte |
| dec_valid | output | 1 | One-cycle pulse: a supported instruction ends on this beat |
| dec_unsup | output | 1 | One-cycle pulse: an unsupported sequence was aborted on this beat |
| dec_op | output | 3 | Operation code |
| dec_mem | output | 1 | Operand is memory |
| dec_reg | output | 3 | Operand code from the opcode |
| dec_index | output | 2 | 00 none, 01 first index register, 10 second |
| dec_disp | output | 16 | Sign-extended displacement (0 in the short layout) |
| dec_len | output | 3 | Instruction length in bytes |
| dec_cycles | output | 5 | Nominal cycle count |

## Verification
Every result is combinational from the current byte and the registered decode progress. So `dec_valid`, `dec_unsup` and all fields are due in the same cycle as the final byte, before the clock edge that consumes it. The bench drives each byte just after a falling edge and samples one time unit later, well before the next rising edge. It also samples every non-final beat and every idle gap beat, where it expects no pulse. The sweeps cover all 256 opcode values in each layout and all 256 displacement values, and the expected fields are computed arithmetically from the byte values.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 3;
  localparam int CYC_W  = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_SHORT, S_IDX, S_IDX_PFX, S_IDX_OPC
  } dec_state_e;

  localparam logic [1:0] IDX_NONE = 2'b00;
  localparam logic [1:0] IDX_FIRST = 2'b01;
  localparam logic [1:0] IDX_SECOND = 2'b10;

  localparam logic [BYTE_W-1:0] BYTE_GROUP  = 8'hCB;
  localparam logic [BYTE_W-1:0] BYTE_IDX_A  = 8'hDD;
  localparam logic [BYTE_W-1:0] BYTE_IDX_B  = 8'hFD;
  localparam logic [2:0]        OPND_MEMORY = 3'b110;
  localparam logic [2:0]        OP_UNDEF    = 3'b110;
endpackage

// File: rtl/bitop_seq.sv
module bitop_seq
  import bitop_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              short_fin,
  output logic              idx_fin,
  output logic              pfx_abort,
  output logic [1:0]        idx_q,
  output logic [BYTE_W-1:0] disp_q
);
  dec_state_e state_q, state_d;
  logic [1:0]        idx_d;
  logic [BYTE_W-1:0] disp_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    disp_d  = disp_q;
    if (in_valid) begin
      unique case (state_q)
        S_IDLE: begin
          if (in_byte == BYTE_GROUP) begin
            state_d = S_SHORT;
            idx_d   = IDX_NONE;
          end else if (in_byte == BYTE_IDX_A) begin
            state_d = S_IDX;
            idx_d   = IDX_FIRST;
          end else if (in_byte == BYTE_IDX_B) begin
            state_d = S_IDX;
            idx_d   = IDX_SECOND;
          end
        end
        S_SHORT:   state_d = S_IDLE;
        S_IDX:     state_d = (in_byte == BYTE_GROUP) ? S_IDX_PFX : S_IDLE;
        S_IDX_PFX: begin
          state_d = S_IDX_OPC;
          disp_d  = in_byte;
        end
        S_IDX_OPC: state_d = S_IDLE;
        default:   state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      idx_q   <= IDX_NONE;
      disp_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      disp_q  <= disp_d;
    end
  end

  assign short_fin = in_valid && (state_q == S_SHORT);
  assign idx_fin   = in_valid && (state_q == S_IDX_OPC);
  assign pfx_abort = in_valid && (state_q == S_IDX) && (in_byte != BYTE_GROUP);

  // R2: the held displacement survives idle beats while the opcode is awaited
  p_disp_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDX_OPC && !in_valid) |=> ($stable(disp_q) && state_q == S_IDX_OPC));

  // R9: every completed or aborted sequence leaves the decoder idle
  p_idle_after_end_r9: assert property (@(posedge clk) disable iff (rst)
    (short_fin || idx_fin || pfx_abort) |=> (state_q == S_IDLE));

  // R5: an indexed opcode beat always carries an index selection
  p_idx_known_r5: assert property (@(posedge clk) disable iff (rst)
    idx_fin |-> (idx_q != IDX_NONE));
endmodule

// File: rtl/bitop_field.sv
module bitop_field
  import bitop_pkg::*;
#(
  parameter int CYC_REG  = 8,
  parameter int CYC_MEM  = 15,
  parameter int CYC_IDX  = 23,
  parameter int LEN_SHORT = 2,
  parameter int LEN_IDX   = 4
) (
  input  logic [BYTE_W-1:0] opc,
  input  logic              indexed,
  output logic              opc_ok,
  output logic [2:0]        op,
  output logic [2:0]        opnd,
  output logic              mem,
  output logic [LEN_W-1:0]  len,
  output logic [CYC_W-1:0]  cycles
);
  logic top_ok;
  logic op_ok;
  logic opnd_ok;

  assign op      = opc[5:3];
  assign opnd    = opc[2:0];
  assign mem     = (opnd == OPND_MEMORY);
  assign top_ok  = (opc[7:6] == 2'b00);
  assign op_ok   = (op != OP_UNDEF);
  assign opnd_ok = !indexed || mem;
  assign opc_ok  = top_ok && op_ok && opnd_ok;

  always_comb begin
    if (indexed) begin
      len    = LEN_W'(LEN_IDX);
      cycles = CYC_W'(CYC_IDX);
    end else begin
      len    = LEN_W'(LEN_SHORT);
      cycles = mem ? CYC_W'(CYC_MEM) : CYC_W'(CYC_REG);
    end
  end
endmodule

// File: rtl/bitop_disp_ext.sv
module bitop_disp_ext
  import bitop_pkg::*;
#(
  parameter int DISP_W = 16
) (
  input  logic [BYTE_W-1:0] raw,
  input  logic              enable,
  output logic [DISP_W-1:0] ext
);
  logic [DISP_W-1:0] widened;

  generate
    if (DISP_W > BYTE_W) begin : g_widen
      assign widened = {{(DISP_W-BYTE_W){raw[BYTE_W-1]}}, raw};
    end else begin : g_same
      assign widened = raw[DISP_W-1:0];
    end
  endgenerate

  assign ext = enable ? widened : '0;
endmodule

// File: rtl/bitop_decoder.sv
module bitop_decoder
  import bitop_pkg::*;
#(
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  output logic              dec_valid,
  output logic              dec_unsup,
  output logic [2:0]        dec_op,
  output logic              dec_mem,
  output logic [2:0]        dec_reg,
  output logic [1:0]        dec_index,
  output logic [DISP_W-1:0] dec_disp,
  output logic [2:0]        dec_len,
  output logic [4:0]        dec_cycles
);
  logic              short_fin;
  logic              idx_fin;
  logic              pfx_abort;
  logic [1:0]        idx_q;
  logic [BYTE_W-1:0] disp_q;
  logic              opc_ok;
  logic              finishing;

  assign in_ready = 1'b1;

  bitop_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .short_fin (short_fin),
    .idx_fin   (idx_fin),
    .pfx_abort (pfx_abort),
    .idx_q     (idx_q),
    .disp_q    (disp_q)
  );

  bitop_field u_field (
    .opc     (in_byte),
    .indexed (idx_fin),
    .opc_ok  (opc_ok),
    .op      (dec_op),
    .opnd    (dec_reg),
    .mem     (dec_mem),
    .len     (dec_len),
    .cycles  (dec_cycles)
  );

  bitop_disp_ext #(.DISP_W(DISP_W)) u_disp (
    .raw    (disp_q),
    .enable (idx_fin),
    .ext    (dec_disp)
  );

  assign finishing = short_fin || idx_fin;
  assign dec_index = idx_fin ? idx_q : IDX_NONE;
  assign dec_valid = finishing && opc_ok;
  assign dec_unsup = pfx_abort || (finishing && !opc_ok);

  // R9: result and abort pulses are exclusive
  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(dec_valid && dec_unsup));

  // R9: a result pulse is never followed by another on the next beat
  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);

  // R9: pulses only on accepted beats
  p_on_beat_r9: assert property (@(posedge clk) disable iff (rst)
    (dec_valid || dec_unsup) |-> in_valid);

  // R5: indexed results are memory, four bytes, 23 cycles
  p_idx_shape_r5: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_index != IDX_NONE) |-> (dec_mem && dec_len == 3'd4 && dec_cycles == 5'd23));

  // R4: short-layout timing follows the operand kind
  p_short_cyc_r4: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_index == IDX_NONE) |-> (dec_len == 3'd2 && dec_cycles == (dec_mem ? 5'd15 : 5'd8)));

  // R3: short-layout results carry no displacement
  p_short_disp_r3: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_index == IDX_NONE) |-> (dec_disp == '0));
endmodule

// File: tb/bitop_decoder_tb.sv
module bitop_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_byte;
  logic        dec_valid, dec_unsup, dec_mem;
  logic [2:0]  dec_op, dec_reg, dec_len;
  logic [1:0]  dec_index;
  logic [15:0] dec_disp;
  logic [4:0]  dec_cycles;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitop_decoder u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .dec_valid(dec_valid), .dec_unsup(dec_unsup), .dec_op(dec_op), .dec_mem(dec_mem),
    .dec_reg(dec_reg), .dec_index(dec_index), .dec_disp(dec_disp), .dec_len(dec_len),
    .dec_cycles(dec_cycles)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic beat(input logic v, input logic [7:0] b);
    @(negedge clk);
    in_valid = v;
    in_byte  = b;
    #1;
  endtask

  task automatic expect_quiet(input string tag);
    check(!dec_valid && !dec_unsup && in_ready, tag,
          {61'd0, in_ready, dec_valid, dec_unsup}, 64'd4);
  endtask

  task automatic expect_final(input string tag, input logic [7:0] opc, input logic [1:0] idx,
                              input logic [7:0] d);
    logic ok;
    logic [34:0] act, exp;
    ok = (opc[7:6] == 2'b00) && (opc[5:3] != 3'b110) && (idx == 2'b00 || opc[2:0] == 3'b110);
    act = {dec_valid, dec_unsup, dec_op, dec_mem, dec_reg, dec_index, dec_disp, dec_len, dec_cycles};
    if (ok) begin
      exp = {1'b1, 1'b0, opc[5:3], opc[2:0] == 3'b110, opc[2:0], idx,
             (idx != 2'b00) ? {{8{d[7]}}, d} : 16'h0000,
             (idx != 2'b00) ? 3'd4 : 3'd2,
             (idx != 2'b00) ? 5'd23 : ((opc[2:0] == 3'b110) ? 5'd15 : 5'd8)};
      check(act == exp, tag, {29'd0, act}, {29'd0, exp});
    end else begin
      check(!dec_valid && dec_unsup, tag, {62'd0, dec_valid, dec_unsup}, 64'd1);
    end
  endtask

  task automatic short_seq(input string tag, input logic [7:0] opc);
    beat(1'b1, 8'hCB); expect_quiet("R3 prefix beat");
    beat(1'b1, opc);   expect_final(tag, opc, 2'b00, 8'h00);
  endtask

  task automatic idx_seq(input string tag, input logic [7:0] pfx, input logic [7:0] d,
                         input logic [7:0] opc, input bit gap);
    logic [1:0] idx;
    idx = (pfx == 8'hDD) ? 2'b01 : 2'b10;
    beat(1'b1, pfx);   expect_quiet("R5 index beat");
    beat(1'b1, 8'hCB); expect_quiet("R5 group beat");
    beat(1'b1, d);     expect_quiet("R5 displacement beat");
    if (gap) begin
      beat(1'b0, 8'hCB); expect_quiet("R2 idle gap beat");
      beat(1'b0, 8'h00); expect_quiet("R2 idle gap beat");
    end
    beat(1'b1, opc);   expect_final(tag, opc, idx, d);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_byte = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1; expect_quiet("R1 reset state");

    // R10: bare opcode bytes and other bytes in idle produce nothing
    beat(1'b1, 8'h16); expect_quiet("R10 bare opcode");
    beat(1'b1, 8'h00); expect_quiet("R10 other byte");
    beat(1'b1, 8'hED); expect_quiet("R10 other byte");

    // R3/R4 named examples
    short_seq("R4 memory rotate-left-through-carry 16", 8'h16);
    short_seq("R3 arithmetic shift right A 2F", 8'h2F);
    short_seq("R3 logical shift right B 38", 8'h38);

    // R1: reset in mid-sequence drops the progress
    beat(1'b1, 8'hCB); expect_quiet("R1 prefix before reset");
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    beat(1'b1, 8'h06); expect_quiet("R1 opcode after reset ignored");
    beat(1'b1, 8'hDD); expect_quiet("R1 index beat");
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    beat(1'b1, 8'h00); expect_quiet("R1 non-group byte after reset ignored");

    // R6: abort after an index prefix, then recovery
    beat(1'b1, 8'hDD); expect_quiet("R6 index beat");
    beat(1'b1, 8'h16);
    check(dec_unsup && !dec_valid, "R6 abort pulse", {62'd0, dec_valid, dec_unsup}, 64'd1);
    beat(1'b1, 8'h16); expect_quiet("R6 idle after abort");
    beat(1'b1, 8'hFD); expect_quiet("R6 index beat");
    beat(1'b1, 8'hDD);
    check(dec_unsup && !dec_valid, "R6 abort on second prefix", {62'd0, dec_valid, dec_unsup}, 64'd1);
    beat(1'b0, 8'h00); expect_quiet("R9 single-cycle abort pulse");
    short_seq("R6 recovery", 8'h06);
    beat(1'b0, 8'h00); expect_quiet("R9 single-cycle result pulse");

    // R2: idle gaps inside the short layout
    beat(1'b1, 8'hCB);
    beat(1'b0, 8'h16); expect_quiet("R2 gap in short layout");
    beat(1'b1, 8'h0A); expect_final("R2 short after gap", 8'h0A, 2'b00, 8'h00);

    // Full opcode sweep, short layout (R3, R4, R8)
    for (int i = 0; i < 256; i++) short_seq("R3 R4 R8 short sweep", 8'(i));

    // Full opcode sweep, indexed layouts (R5, R7, R8)
    for (int i = 0; i < 256; i++)
      idx_seq("R5 R7 R8 first index sweep", 8'hDD, 8'(i) ^ 8'h5A, 8'(i), i[0]);
    for (int i = 0; i < 256; i++)
      idx_seq("R5 R7 R8 second index sweep", 8'hFD, 8'(255 - i), 8'(i), i[1]);

    // Displacement sweep (R5 sign extension)
    for (int i = 0; i < 256; i++)
      idx_seq("R5 displacement sweep", (i % 2 == 0) ? 8'hDD : 8'hFD, 8'(i),
              (i % 3 == 0) ? 8'h3E : 8'h16, i[2]);

    beat(1'b0, 8'h00); expect_quiet("R9 quiet at end");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule